// File: doc/BRIEF.md
# Bus-Matching Byte-Swapping Output Port

This block drains a 36-bit-wide queue through a read port whose width is chosen at run time. Each queue entry is four 9-bit bytes. When the block fetches an entry, it can reorder those bytes. It then holds the result in a staging register. The entry leaves the port as one 36-bit long word, as two 18-bit words or as four 9-bit bytes, one part for each accepted read enable.

Configuration inputs set the part size, the byte reordering and the order in which the parts come out. These inputs are sampled only when a new entry is fetched, so a change made during a partial drain takes effect with the following entry.

The queue presents its head entry ahead of the pop, together with an empty flag. The block requests a pop in the same cycle as the read that fetches the entry.

Top module: `bus_match_port`

## Requirements
- R1: While rst_ni is low and after its release, rd_data_o is zero and q_pop_o is low. The staging register starts empty, so the first accepted read fetches from the queue.
- R2: Size code size_sel_i is encoded as follows: 00 gives one 36-bit part per entry, 01 gives two 18-bit parts, 10 gives four 9-bit parts, and 11 behaves like 00. q_pop_o is high, combinationally, only in a cycle where rd_en_i is high, the staging register is exhausted and q_empty_i is low. So in 18-bit mode there is one pop per two accepted reads, and in 9-bit mode one pop per four.
- R3: rd_data_o is registered. The part selected by an accepted read appears on it after the rising clock edge at which rd_en_i is sampled high.
- R4: With big_endian_i high, parts leave most significant first: bits [35:27], [26:18], [17:9], [8:0] in 9-bit mode, and [35:18] then [17:0] in 18-bit mode. With big_endian_i low, parts leave least significant first.
- R5: Let the fetched entry be the bytes {b3,b2,b1,b0}, where b3 is bits [35:27]. swap_sel_i then gives the following staged word: 00 gives {b3,b2,b1,b0}; 01 gives {b0,b1,b2,b3}; 10 gives {b1,b0,b3,b2}; 11 gives {b2,b3,b0,b1}.
- R6: In 18-bit mode, rd_data_o[35:18] is zero. In 9-bit mode, rd_data_o[35:9] is zero.
- R7: A rd_en_i that arrives while the staging register is exhausted and q_empty_i is high is ignored. There is no pop, and rd_data_o keeps its value.
- R8: size_sel_i, big_endian_i and swap_sel_i are sampled only on the read that fetches an entry. Changes made during the drain of that entry do not affect its remaining parts.
- R9: With rd_en_i low, rd_data_o holds and q_pop_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| q_data_i | input | 36 | Queue head entry, valid while q_empty_i is low |
| q_empty_i | input | 1 | Queue holds no entry |
| rd_en_i | input | 1 | Port read enable |
| size_sel_i | input | 2 | Part size: 00 36-bit, 01 18-bit, 10 9-bit, 11 36-bit |
| big_endian_i | input | 1 | 1: most significant part first |
| swap_sel_i | input | 2 | Byte reorder applied at fetch |
| rd_data_o | output | 36 | Port read data, zero-extended |
| q_pop_o | output | 1 | Pop request to the queue |

## Verification
A wrong remaining-part count would show up at the ports within one entry. A pop would come a read too early or too late, visible on q_pop_o in that same cycle, and the next part on rd_data_o would come from the wrong entry on the following edge.

A wrong part index or a wrong latched endian setting would put the wrong byte or half on rd_data_o right after the read that selects it. A wrong latched swap code would corrupt the first part of that entry.

Because settings are latched at fetch, the stimulus changes them at random in the middle of drains. A block that used the live inputs would then show mismatches within a few reads.

// File: rtl/bmp_pkg.sv
package bmp_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned IDX_W = 2;

  typedef enum logic [1:0] {
    SZ_FULL = 2'b00,
    SZ_HALF = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    SW_NONE  = 2'b00,
    SW_REV   = 2'b01,
    SW_HALVES = 2'b10,
    SW_INNER = 2'b11
  } swap_e;

  // parts per entry, minus one
  function automatic logic [IDX_W-1:0] last_part(size_e s);
    case (s)
      SZ_HALF: last_part = IDX_W'(1);
      SZ_BYTE: last_part = IDX_W'(LANES - 1);
      default: last_part = '0;
    endcase
  endfunction

  // source lane xor-mask for each swap code
  function automatic logic [IDX_W-1:0] lane_mask(swap_e s);
    case (s)
      SW_REV:    lane_mask = IDX_W'(3);
      SW_HALVES: lane_mask = IDX_W'(2);
      SW_INNER:  lane_mask = IDX_W'(1);
      default:   lane_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/bmp_swap.sv
module bmp_swap
  import bmp_pkg::*;
#(
  parameter int unsigned BYTE_W = 9,
  localparam int unsigned WORD_W = LANES * BYTE_W
) (
  input  logic [WORD_W-1:0] word_i,
  input  swap_e             mode_i,
  output logic [WORD_W-1:0] word_o
);
  logic [IDX_W-1:0] mask;
  assign mask = lane_mask(mode_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IDX_W-1:0] src;
    assign src = IDX_W'(g) ^ mask;
    assign word_o[g*BYTE_W +: BYTE_W] = word_i[src*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/bmp_part_sel.sv
module bmp_part_sel
  import bmp_pkg::*;
#(
  parameter int unsigned BYTE_W = 9,
  localparam int unsigned WORD_W = LANES * BYTE_W,
  localparam int unsigned HALF_W = 2 * BYTE_W
) (
  input  logic [WORD_W-1:0] word_i,
  input  size_e             size_i,
  input  logic              big_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [WORD_W-1:0] part_o
);
  logic [IDX_W-1:0] lane_no;
  logic             half_no;

  assign lane_no = big_i ? (IDX_W'(LANES - 1) - idx_i) : idx_i;
  assign half_no = big_i ? ~idx_i[0] : idx_i[0];

  always_comb begin
    part_o = '0;
    case (size_i)
      SZ_BYTE: part_o[BYTE_W-1:0] = word_i[lane_no*BYTE_W +: BYTE_W];
      SZ_HALF: part_o[HALF_W-1:0] = word_i[half_no*HALF_W +: HALF_W];
      default: part_o = word_i;
    endcase
  end
endmodule

// File: rtl/bmp_ctrl.sv
module bmp_ctrl
  import bmp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic             q_empty_i,
  input  size_e            size_i,
  output logic             load_o,
  output logic             adv_o,
  output logic             drained_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] left_q, idx_q;

  assign drained_o = (left_q == '0);
  assign load_o    = rd_en_i && drained_o && !q_empty_i;
  assign adv_o     = rd_en_i && !drained_o;
  assign idx_o     = load_o ? '0 : idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      idx_q  <= '0;
    end else if (load_o) begin
      left_q <= last_part(size_i);
      idx_q  <= IDX_W'(1);
    end else if (adv_o) begin
      left_q <= left_q - IDX_W'(1);
      idx_q  <= idx_q + IDX_W'(1);
    end
  end

  // parts pending implies at least one part already delivered
  assert_idx_pending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q != '0) |-> (idx_q != '0));

  assert_load_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_o && adv_o));
endmodule

// File: rtl/bus_match_port.sv
module bus_match_port
  import bmp_pkg::*;
#(
  parameter int unsigned BYTE_W = 9,
  localparam int unsigned WORD_W = LANES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] q_data_i,
  input  logic              q_empty_i,
  input  logic              rd_en_i,
  input  logic [1:0]        size_sel_i,
  input  logic              big_endian_i,
  input  logic [1:0]        swap_sel_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              q_pop_o
);
  logic              load, adv, drained;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] swapped, stage_q, sel_word, part;
  size_e             size_q, sel_size;
  logic              big_q, sel_big;

  bmp_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .q_empty_i (q_empty_i),
    .size_i    (size_e'(size_sel_i)),
    .load_o    (load),
    .adv_o     (adv),
    .drained_o (drained),
    .idx_o     (idx)
  );

  bmp_swap #(.BYTE_W(BYTE_W)) u_swap (
    .word_i (q_data_i),
    .mode_i (swap_e'(swap_sel_i)),
    .word_o (swapped)
  );

  // fetch path uses live settings, drain path uses latched ones
  assign sel_word = load ? swapped : stage_q;
  assign sel_size = load ? size_e'(size_sel_i) : size_q;
  assign sel_big  = load ? big_endian_i : big_q;

  bmp_part_sel #(.BYTE_W(BYTE_W)) u_sel (
    .word_i (sel_word),
    .size_i (sel_size),
    .big_i  (sel_big),
    .idx_i  (idx),
    .part_o (part)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q   <= '0;
      size_q    <= SZ_FULL;
      big_q     <= 1'b0;
      rd_data_o <= '0;
    end else begin
      if (load) begin
        stage_q <= swapped;
        size_q  <= size_e'(size_sel_i);
        big_q   <= big_endian_i;
      end
      if (load || adv) rd_data_o <= part;
    end
  end

  assign q_pop_o = load;

  assert_pop_nonempty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_pop_o |-> (!q_empty_i && rd_en_i));

  assert_ignored_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && q_empty_i && drained) |=> $stable(rd_data_o));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  assert_byte_upper_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_q == SZ_BYTE) |-> (rd_data_o[WORD_W-1:BYTE_W] == '0));

  assert_half_upper_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_q == SZ_HALF) |-> (rd_data_o[WORD_W-1:2*BYTE_W] == '0));
endmodule

// File: tb/bus_match_port_tb_top.sv
module bus_match_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [35:0] q_data;
  logic        q_empty;
  logic        rd_en = 1'b0;
  logic [1:0]  size_sel = 2'b00;
  logic        big_en = 1'b0;
  logic [1:0]  swap_sel = 2'b00;
  logic [35:0] rd_data;
  logic        q_pop;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [35:0] mem [64];
  logic [6:0]  wp = '0, rp = '0;

  assign q_data  = mem[rp[5:0]];
  assign q_empty = (wp == rp);

  // model state
  int          m_left = 0, m_idx = 0, m_parts = 1;
  logic        m_be = 1'b0;
  logic [35:0] m_stage = '0, m_out = '0;

  always #4 clk = ~clk;

  bus_match_port dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .q_data_i     (q_data),
    .q_empty_i    (q_empty),
    .rd_en_i      (rd_en),
    .size_sel_i   (size_sel),
    .big_endian_i (big_en),
    .swap_sel_i   (swap_sel),
    .rd_data_o    (rd_data),
    .q_pop_o      (q_pop)
  );

  function automatic logic [35:0] swap_f(logic [35:0] w, logic [1:0] c);
    logic [8:0] b0, b1, b2, b3;
    {b3, b2, b1, b0} = w;
    case (c)
      2'b01:   return {b0, b1, b2, b3};
      2'b10:   return {b1, b0, b3, b2};
      2'b11:   return {b2, b3, b0, b1};
      default: return w;
    endcase
  endfunction

  function automatic int parts_f(logic [1:0] s);
    return (s == 2'b01) ? 2 : (s == 2'b10) ? 4 : 1;
  endfunction

  function automatic logic [35:0] part_f(logic [35:0] w, int n, logic be, int k);
    int pw, p;
    logic [63:0] wide, msk;
    pw   = 36 / n;
    p    = be ? (n - 1 - k) : k;
    wide = {28'd0, w} >> (p * pw);
    msk  = (64'd1 << pw) - 64'd1;
    return 36'(wide & msk);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(logic [35:0] v);
    if (7'(wp - rp) < 7'd64) begin
      mem[wp[5:0]] = v;
      wp = wp + 7'd1;
    end
  endtask

  // one cycle: drive at negedge, check pop, advance model after edge, check data
  task automatic step(logic rd, logic [1:0] sz, logic be, logic [1:0] sw,
                      string ptag, string dtag);
    logic exp_pop;
    @(negedge clk);
    rd_en = rd; size_sel = sz; big_en = be; swap_sel = sw;
    #1;
    exp_pop = rd && (m_left == 0) && (wp != rp);
    check(ptag, q_pop, exp_pop);
    @(posedge clk);
    #1;
    if (exp_pop) begin
      m_stage = swap_f(mem[rp[5:0]], sw);
      rp      = rp + 7'd1;
      m_parts = parts_f(sz);
      m_be    = be;
      m_out   = part_f(m_stage, m_parts, m_be, 0);
      m_left  = m_parts - 1;
      m_idx   = 1;
    end else if (rd && m_left > 0) begin
      m_out  = part_f(m_stage, m_parts, m_be, m_idx);
      m_idx++;
      m_left--;
    end
    check(dtag, rd_data, m_out);
  endtask

  localparam logic [35:0] ENT = {9'h1A1, 9'h0B2, 9'h153, 9'h064};

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", rd_data, 36'd0);
    check("R1", q_pop, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", rd_data, 36'd0);

    // R7: read on empty queue with nothing staged
    step(1, 2'b10, 1, 2'b00, "R7", "R7");
    step(1, 2'b00, 0, 2'b00, "R7", "R7");

    // R4 byte big and little
    push(ENT);
    for (int k = 0; k < 4; k++) step(1, 2'b10, 1, 2'b00, "R2", "R4");
    check("R4", rd_data, 36'h064);
    push(ENT);
    for (int k = 0; k < 4; k++) step(1, 2'b10, 0, 2'b00, "R2", "R4");
    check("R4", rd_data, 36'h1A1);

    // R6 half modes, upper bits zero
    push(ENT);
    step(1, 2'b01, 1, 2'b00, "R2", "R6");
    check("R6", rd_data, {18'd0, 9'h1A1, 9'h0B2});
    step(1, 2'b01, 1, 2'b00, "R2", "R6");
    push(ENT);
    step(1, 2'b01, 0, 2'b00, "R2", "R6");
    step(1, 2'b01, 0, 2'b00, "R2", "R6");

    // R5 swap codes in full width (code 11 size too)
    push(ENT); step(1, 2'b00, 0, 2'b01, "R2", "R5");
    check("R5", rd_data, {9'h064, 9'h153, 9'h0B2, 9'h1A1});
    push(ENT); step(1, 2'b11, 1, 2'b10, "R2", "R5");
    check("R5", rd_data, {9'h153, 9'h064, 9'h1A1, 9'h0B2});
    push(ENT); step(1, 2'b00, 1, 2'b11, "R2", "R5");
    check("R5", rd_data, {9'h0B2, 9'h1A1, 9'h064, 9'h153});

    // R9 idle hold
    push(ENT);
    step(0, 2'b10, 1, 2'b01, "R9", "R9");
    step(0, 2'b01, 0, 2'b11, "R9", "R9");

    // R8 settings change mid-drain
    push(36'h9_8765_4321);
    step(1, 2'b10, 1, 2'b00, "R2", "R8");
    step(1, 2'b00, 0, 2'b01, "R8", "R8");
    step(1, 2'b01, 1, 2'b10, "R8", "R8");
    step(1, 2'b00, 0, 2'b11, "R8", "R8");
    check("R8", rd_data, 36'h064);
    step(1, 2'b00, 0, 2'b00, "R2", "R8");
    check("R8", rd_data, 36'h9_8765_4321);
    // R7 again after drain
    step(1, 2'b00, 0, 2'b00, "R7", "R7");

    // R3 random mix
    void'($urandom(32'd4242));
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(9, 0) < 4) push({$urandom(), 4'($urandom())});
      step($urandom_range(9, 0) < 7, 2'($urandom()), 1'($urandom()),
           2'($urandom()), "R2", "R3");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule